// File: doc/BRIEF.md
# Video Input Routing Crossbar

This block steers six incoming pixel streams onto four outgoing video ports and two compression-encoder feeds. Each stream is a bundle of a 48-bit pixel word, a 48-bit metadata word, an active-high data-enable, and active-low vertical and horizontal syncs. A small set of configuration inputs picks the transport mode (one stream or several), which outputs carry compressed data, and how the two encoders are used. The encoders themselves are outside the block. Their compressed results come back on two return ports, and the crossbar can route those results to the outputs.

Configuration is held in a shadow. It is taken over only at the start of a frame on input 2, which is the stream behind output port 0, so a route never changes mid-frame. The block also performs three other duties. It flags configurations that cannot be built and forces every output idle while they are active. It extracts the secure-mode flag from each routed stream. In split-panel compression, it reports cycles in which the two halves disagree on their sync timing.

Top module: `vid_route_xbar`

## Requirements
- R1: While reset is asserted, every output and encoder lane is idle: data-enable 0, both syncs 1, pixel and metadata 0, secure 0. `cfg_err` and `sync_mismatch` are 0. The active configuration resets to single-stream with no compression.
- R2: Every routed lane is registered exactly once. The pixel, metadata, enable and syncs of a lane at clock edge n+1 are those of its source sampled at edge n.
- R3: In single-stream mode (`cfg_mst`=0) with compression off (`cfg_comp_out[0]`=0), output 0 carries input 2. Outputs 1 to 3 and both encoder lanes are idle.
- R4: In multi-stream mode with no compression, output 1 carries input 3. Output 2 carries input 4 when `cfg_alt_sel[0]`=1 and input 2 otherwise. Output 3 carries input 5 when `cfg_alt_sel[1]`=1 and input 3 otherwise.
- R5: With compression on and `cfg_enc_mode`=0 (single encoder) and `cfg_enc_src`=2, encoder 0 receives input 2, encoder 1 is idle, and output 0 carries return port 0.
- R6: With `cfg_enc_mode`=1 (split panel), which is legal in either transport mode, encoder 0 receives input 2 and encoder 1 receives input 3. Output 0 carries return port 0. Output 1 is idle.
- R7: `cfg_enc_mode`=2 (dual panel) is legal only in multi-stream mode. Encoder 0 receives input 2 and encoder 1 receives input 3, and output 0 carries return port 0. Output 1 carries return port 1 when `cfg_comp_out[1]`=1 and input 3 otherwise.
- R8: `cfg_err` is 1, and all six lanes are idle, whenever any of the following holds:
  - `cfg_comp_out[2]` or `cfg_comp_out[3]` is set;
  - compression is on with `cfg_enc_mode`=3;
  - compression is on in single-encoder mode with `cfg_enc_src`≠2;
  - dual panel is selected in single-stream mode;
  - `cfg_comp_out[1]` is set outside dual panel with compression on.

  `cfg_err` is registered and aligned with the lanes.
- R9: Each lane's secure output equals bit 10 of the metadata word it carries, and is 0 when the lane is idle.
- R10: `sync_mismatch` is 1 one cycle after a cycle in which split panel is in force and input 2 and input 3 differ in data-enable, vertical sync or horizontal sync. It is 0 otherwise.
- R11: The configuration inputs take effect only in a cycle where `in_vs_n[2]` falls (it was 1 in the previous cycle and is 0 now). The new route already applies to that cycle's data. In all other cycles, changes on the configuration inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mst | input | 1 | 1 = multi-stream transport |
| cfg_comp_out | input | 4 | Per output: carry compressed data |
| cfg_enc_mode | input | 2 | 0 single encoder, 1 split panel, 2 dual panel, 3 reserved |
| cfg_enc_src | input | 3 | Input index feeding encoder 0 in single-encoder mode |
| cfg_alt_sel | input | 2 | Bit 0: output 2 from input 4; bit 1: output 3 from input 5 |
| in_pix | input | 6x48 | Pixel word per input |
| in_meta | input | 6x48 | Metadata word per input (bit 10 secure) |
| in_de | input | 6 | Data enable per input, active high |
| in_vs_n | input | 6 | Vertical sync per input, active low |
| in_hs_n | input | 6 | Horizontal sync per input, active low |
| ret_pix | input | 2x48 | Compressed pixel word from each encoder |
| ret_meta | input | 2x48 | Compressed metadata from each encoder |
| ret_de | input | 2 | Compressed data enable |
| ret_vs_n | input | 2 | Compressed vertical sync |
| ret_hs_n | input | 2 | Compressed horizontal sync |
| vif_pix | output | 4x48 | Pixel word per output port |
| vif_meta | output | 4x48 | Metadata per output port |
| vif_de | output | 4 | Data enable per output port |
| vif_vs_n | output | 4 | Vertical sync per output port |
| vif_hs_n | output | 4 | Horizontal sync per output port |
| vif_secure | output | 4 | Secure flag per output port |
| enc_pix | output | 2x48 | Pixel word to each encoder |
| enc_meta | output | 2x48 | Metadata to each encoder |
| enc_de | output | 2 | Data enable to each encoder |
| enc_vs_n | output | 2 | Vertical sync to each encoder |
| enc_hs_n | output | 2 | Horizontal sync to each encoder |
| enc_secure | output | 2 | Secure flag to each encoder |
| cfg_err | output | 1 | Active configuration is illegal |
| sync_mismatch | output | 1 | Split-panel halves disagree in timing |

## Verification
All six inputs and both return ports carry independent random pixel, metadata and sync values every cycle. Any lane that picks the wrong source therefore shows up as a value mismatch, and any lane that is off by one cycle does too. Each transport, alternate-select and encoder mode is entered through a frame start on input 2, after a few cycles in which the new settings are already present but must still be ignored. This separates correct frame-aligned switching from immediate switching. Split panel is run once with inputs 2 and 3 sharing their sync bits and once with them independent, so that the mismatch flag is shown both silent and firing. Dual panel with unrelated timing shows that the flag stays low there. Each illegal combination is applied in turn, followed by a legal one, to show that the lanes go fully idle and then recover.

// File: rtl/vrx_pkg.sv
`timescale 1ns/1ps
package vrx_pkg;
    localparam int PIX_W   = 48;
    localparam int META_W  = 48;
    localparam int SEC_BIT = 10;
    localparam int N_IN    = 6;
    localparam int N_RET   = 2;
    localparam int N_VIF   = 4;
    localparam int N_ENC   = 2;
    localparam int N_SRC   = N_IN + N_RET;
    localparam int N_LANE  = N_VIF + N_ENC;
    localparam int IDX_W   = $clog2(N_SRC);

    localparam int SRC_IN2  = 2;
    localparam int SRC_IN3  = 3;
    localparam int SRC_IN4  = 4;
    localparam int SRC_IN5  = 5;
    localparam int SRC_RET0 = N_IN;
    localparam int SRC_RET1 = N_IN + 1;

    localparam int LANE_ENC0 = N_VIF;
    localparam int LANE_ENC1 = N_VIF + 1;

    typedef enum logic [1:0] {
        ENC_SINGLE = 2'd0,
        ENC_SPLIT  = 2'd1,
        ENC_DUAL   = 2'd2,
        ENC_RSVD   = 2'd3
    } enc_mode_e;

    typedef struct packed {
        logic [PIX_W-1:0]  pix;
        logic [META_W-1:0] meta;
        logic              de;
        logic              vs_n;
        logic              hs_n;
    } vstrm_t;

    typedef struct packed {
        logic              mst;
        logic [N_VIF-1:0]  comp;
        enc_mode_e         mode;
        logic [IDX_W-1:0]  src;
        logic [1:0]        alt;
    } rcfg_t;

    typedef struct packed {
        logic             on;
        logic [IDX_W-1:0] idx;
    } rsel_t;

    localparam vstrm_t STRM_IDLE = '{pix: '0, meta: '0, de: 1'b0, vs_n: 1'b1, hs_n: 1'b1};
    localparam rsel_t  SEL_OFF   = '{on: 1'b0, idx: '0};
    localparam rcfg_t  CFG_RESET = '{mst: 1'b0, comp: '0, mode: ENC_SINGLE, src: '0, alt: '0};

    function automatic rsel_t pick(input int unsigned i);
        rsel_t r;
        r.on  = 1'b1;
        r.idx = IDX_W'(i);
        return r;
    endfunction
endpackage

// File: rtl/vrx_cfg_ctrl.sv
`timescale 1ns/1ps
module vrx_cfg_ctrl
    import vrx_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  rcfg_t                   cfg_in,
    input  logic                    frame_vs_n,
    output rsel_t [N_LANE-1:0]      sel,
    output logic                    illegal,
    output logic                    split_on
);
    typedef struct packed {
        rcfg_t act;
        logic  vs_prev;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    rcfg_t eff;
    logic  frame_fall;
    logic  comp_on;

    always_comb begin
        frame_fall    = ctl_q.vs_prev & ~frame_vs_n;
        eff           = frame_fall ? cfg_in : ctl_q.act;
        ctl_d.act     = eff;
        ctl_d.vs_prev = frame_vs_n;
        comp_on       = eff.comp[0];

        illegal = eff.comp[2] | eff.comp[3]
                | (comp_on && eff.mode == ENC_RSVD)
                | (comp_on && eff.mode == ENC_SINGLE && eff.src != IDX_W'(SRC_IN2))
                | (comp_on && eff.mode == ENC_DUAL && !eff.mst)
                | (eff.comp[1] && !(comp_on && eff.mode == ENC_DUAL));

        sel      = {N_LANE{SEL_OFF}};
        split_on = 1'b0;
        if (!illegal) begin
            sel[0] = comp_on ? pick(SRC_RET0) : pick(SRC_IN2);
            if (comp_on) begin
                sel[LANE_ENC0] = pick(SRC_IN2);
                if (eff.mode != ENC_SINGLE) begin
                    sel[LANE_ENC1] = pick(SRC_IN3);
                end
                split_on = (eff.mode == ENC_SPLIT);
            end
            if (eff.mst) begin
                if (eff.comp[1]) begin
                    sel[1] = pick(SRC_RET1);
                end else if (!(comp_on && eff.mode == ENC_SPLIT)) begin
                    sel[1] = pick(SRC_IN3);
                end
                sel[2] = eff.alt[0] ? pick(SRC_IN4) : pick(SRC_IN2);
                sel[3] = eff.alt[1] ? pick(SRC_IN5) : pick(SRC_IN3);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{act: CFG_RESET, vs_prev: 1'b1};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R11: route state only moves at a frame start
    a_r11_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_fall |=> $stable(ctl_q.act));

    // R6: second encoder is never fed alone
    a_r6_enc1_needs_enc0: assert property (@(posedge clk) disable iff (!rst_n)
        sel[LANE_ENC1].on |-> sel[LANE_ENC0].on);

    // R3: single-stream mode drives port 0 only
    a_r3_sst_port0_only: assert property (@(posedge clk) disable iff (!rst_n)
        !eff.mst |-> !(sel[1].on || sel[2].on || sel[3].on));
endmodule

// File: rtl/vrx_lane_reg.sv
`timescale 1ns/1ps
module vrx_lane_reg
    import vrx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  rsel_t                sel,
    input  vstrm_t [N_SRC-1:0]   srcs,
    output vstrm_t               q,
    output logic                 sec_q
);
    typedef struct packed {
        vstrm_t s;
        logic   sec;
    } lane_t;

    lane_t lane_d, lane_q;

    always_comb begin
        lane_d.s   = sel.on ? srcs[sel.idx] : STRM_IDLE;
        lane_d.sec = lane_d.s.meta[SEC_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '{s: STRM_IDLE, sec: 1'b0};
        end else begin
            lane_q <= lane_d;
        end
    end

    assign q     = lane_q.s;
    assign sec_q = lane_q.sec;

    // R8 / R9: a lane left unselected presents the idle pattern
    a_r8_unselected_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel.on) |-> (q == STRM_IDLE && !sec_q));
endmodule

// File: rtl/vrx_sync_cmp.sv
`timescale 1ns/1ps
module vrx_sync_cmp
    import vrx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  vstrm_t a,
    input  vstrm_t b,
    output logic   mismatch
);
    typedef struct packed {
        logic mm;
    } cmp_t;

    cmp_t cmp_d, cmp_q;

    always_comb begin
        cmp_d.mm = en & ((a.de ^ b.de) | (a.vs_n ^ b.vs_n) | (a.hs_n ^ b.hs_n));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else begin
            cmp_q <= cmp_d;
        end
    end

    assign mismatch = cmp_q.mm;

    // R10: flag only follows a split-panel cycle
    a_r10_split_only: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |-> $past(en));
endmodule

// File: rtl/vid_route_xbar.sv
`timescale 1ns/1ps
module vid_route_xbar
    import vrx_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_mst,
    input  logic [N_VIF-1:0]               cfg_comp_out,
    input  logic [1:0]                     cfg_enc_mode,
    input  logic [IDX_W-1:0]               cfg_enc_src,
    input  logic [1:0]                     cfg_alt_sel,
    input  logic [N_IN-1:0][PIX_W-1:0]     in_pix,
    input  logic [N_IN-1:0][META_W-1:0]    in_meta,
    input  logic [N_IN-1:0]                in_de,
    input  logic [N_IN-1:0]                in_vs_n,
    input  logic [N_IN-1:0]                in_hs_n,
    input  logic [N_RET-1:0][PIX_W-1:0]    ret_pix,
    input  logic [N_RET-1:0][META_W-1:0]   ret_meta,
    input  logic [N_RET-1:0]               ret_de,
    input  logic [N_RET-1:0]               ret_vs_n,
    input  logic [N_RET-1:0]               ret_hs_n,
    output logic [N_VIF-1:0][PIX_W-1:0]    vif_pix,
    output logic [N_VIF-1:0][META_W-1:0]   vif_meta,
    output logic [N_VIF-1:0]               vif_de,
    output logic [N_VIF-1:0]               vif_vs_n,
    output logic [N_VIF-1:0]               vif_hs_n,
    output logic [N_VIF-1:0]               vif_secure,
    output logic [N_ENC-1:0][PIX_W-1:0]    enc_pix,
    output logic [N_ENC-1:0][META_W-1:0]   enc_meta,
    output logic [N_ENC-1:0]               enc_de,
    output logic [N_ENC-1:0]               enc_vs_n,
    output logic [N_ENC-1:0]               enc_hs_n,
    output logic [N_ENC-1:0]               enc_secure,
    output logic                           cfg_err,
    output logic                           sync_mismatch
);
    typedef struct packed {
        logic err;
    } top_t;

    vstrm_t [N_SRC-1:0]  srcs;
    vstrm_t [N_LANE-1:0] lane_q;
    logic   [N_LANE-1:0] lane_sec;
    rsel_t  [N_LANE-1:0] sel;
    rcfg_t               cfg_in;
    logic                illegal;
    logic                split_on;
    top_t                top_d, top_q;

    for (genvar i = 0; i < N_IN; i++) begin : g_src_in
        assign srcs[i] = '{pix: in_pix[i], meta: in_meta[i], de: in_de[i],
                           vs_n: in_vs_n[i], hs_n: in_hs_n[i]};
    end
    for (genvar r = 0; r < N_RET; r++) begin : g_src_ret
        assign srcs[N_IN + r] = '{pix: ret_pix[r], meta: ret_meta[r], de: ret_de[r],
                                  vs_n: ret_vs_n[r], hs_n: ret_hs_n[r]};
    end

    always_comb begin
        cfg_in.mst  = cfg_mst;
        cfg_in.comp = cfg_comp_out;
        cfg_in.mode = enc_mode_e'(cfg_enc_mode);
        cfg_in.src  = cfg_enc_src;
        cfg_in.alt  = cfg_alt_sel;
    end

    vrx_cfg_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_in     (cfg_in),
        .frame_vs_n (in_vs_n[SRC_IN2]),
        .sel        (sel),
        .illegal    (illegal),
        .split_on   (split_on)
    );

    for (genvar k = 0; k < N_LANE; k++) begin : g_lane
        vrx_lane_reg u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (sel[k]),
            .srcs  (srcs),
            .q     (lane_q[k]),
            .sec_q (lane_sec[k])
        );
    end

    vrx_sync_cmp u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (split_on),
        .a        (srcs[SRC_IN2]),
        .b        (srcs[SRC_IN3]),
        .mismatch (sync_mismatch)
    );

    always_comb begin
        top_d.err = illegal;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign cfg_err = top_q.err;

    for (genvar v = 0; v < N_VIF; v++) begin : g_vif
        assign vif_pix[v]    = lane_q[v].pix;
        assign vif_meta[v]   = lane_q[v].meta;
        assign vif_de[v]     = lane_q[v].de;
        assign vif_vs_n[v]   = lane_q[v].vs_n;
        assign vif_hs_n[v]   = lane_q[v].hs_n;
        assign vif_secure[v] = lane_sec[v];
    end
    for (genvar e = 0; e < N_ENC; e++) begin : g_enc
        assign enc_pix[e]    = lane_q[N_VIF + e].pix;
        assign enc_meta[e]   = lane_q[N_VIF + e].meta;
        assign enc_de[e]     = lane_q[N_VIF + e].de;
        assign enc_vs_n[e]   = lane_q[N_VIF + e].vs_n;
        assign enc_hs_n[e]   = lane_q[N_VIF + e].hs_n;
        assign enc_secure[e] = lane_sec[N_VIF + e];
    end

    // R8: an illegal setting leaves every lane quiet
    a_r8_err_forces_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (vif_de == '0 && enc_de == '0 && vif_secure == '0 && enc_secure == '0));

    // R10: no timing flag while the configuration is rejected
    a_r10_quiet_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !sync_mismatch);
endmodule

// File: tb/test_vid_route_xbar.sv
`timescale 1ns/1ps
module test_vid_route_xbar;
    import vrx_pkg::*;

    logic                         clk = 1'b0;
    logic                         rst_n = 1'b0;
    logic                         cfg_mst = 1'b0;
    logic [N_VIF-1:0]             cfg_comp_out = '0;
    logic [1:0]                   cfg_enc_mode = '0;
    logic [IDX_W-1:0]             cfg_enc_src = '0;
    logic [1:0]                   cfg_alt_sel = '0;
    logic [N_IN-1:0][PIX_W-1:0]   in_pix = '0;
    logic [N_IN-1:0][META_W-1:0]  in_meta = '0;
    logic [N_IN-1:0]              in_de = '0;
    logic [N_IN-1:0]              in_vs_n = '1;
    logic [N_IN-1:0]              in_hs_n = '1;
    logic [N_RET-1:0][PIX_W-1:0]  ret_pix = '0;
    logic [N_RET-1:0][META_W-1:0] ret_meta = '0;
    logic [N_RET-1:0]             ret_de = '0;
    logic [N_RET-1:0]             ret_vs_n = '1;
    logic [N_RET-1:0]             ret_hs_n = '1;
    logic [N_VIF-1:0][PIX_W-1:0]  vif_pix;
    logic [N_VIF-1:0][META_W-1:0] vif_meta;
    logic [N_VIF-1:0]             vif_de, vif_vs_n, vif_hs_n, vif_secure;
    logic [N_ENC-1:0][PIX_W-1:0]  enc_pix;
    logic [N_ENC-1:0][META_W-1:0] enc_meta;
    logic [N_ENC-1:0]             enc_de, enc_vs_n, enc_hs_n, enc_secure;
    logic                         cfg_err, sync_mismatch;

    always #4 clk = ~clk;

    vid_route_xbar i_vid_route_xbar (.*);

    typedef struct packed {
        vstrm_t [N_LANE-1:0] lane;
        logic   [N_LANE-1:0] sec;
        logic                err;
        logic                mm;
    } snap_t;

    snap_t exp_q[$];
    string tag_q[$];
    string tag = "R1";
    int    checks = 0;
    int    errors = 0;
    rcfg_t m_act = CFG_RESET;
    logic  m_prev = 1'b1;

    function automatic snap_t observe();
        snap_t s;
        for (int k = 0; k < N_VIF; k++)
            s.lane[k] = '{pix: vif_pix[k], meta: vif_meta[k], de: vif_de[k],
                          vs_n: vif_vs_n[k], hs_n: vif_hs_n[k]};
        for (int e = 0; e < N_ENC; e++)
            s.lane[N_VIF+e] = '{pix: enc_pix[e], meta: enc_meta[e], de: enc_de[e],
                                vs_n: enc_vs_n[e], hs_n: enc_hs_n[e]};
        s.sec = {enc_secure, vif_secure};
        s.err = cfg_err;
        s.mm  = sync_mismatch;
        return s;
    endfunction

    function automatic vstrm_t strm(input int i);
        if (i < N_IN)
            return '{pix: in_pix[i], meta: in_meta[i], de: in_de[i], vs_n: in_vs_n[i], hs_n: in_hs_n[i]};
        return '{pix: ret_pix[i-N_IN], meta: ret_meta[i-N_IN], de: ret_de[i-N_IN],
                 vs_n: ret_vs_n[i-N_IN], hs_n: ret_hs_n[i-N_IN]};
    endfunction

    // Expected result of the current input cycle, from the requirements
    function automatic snap_t predict();
        snap_t e;
        rcfg_t now, eff;
        int    src[N_LANE];
        logic  con, bad;
        now = '{mst: cfg_mst, comp: cfg_comp_out, mode: enc_mode_e'(cfg_enc_mode),
                src: cfg_enc_src, alt: cfg_alt_sel};
        eff    = (m_prev && !in_vs_n[2]) ? now : m_act;   // R11
        m_act  = eff;
        m_prev = in_vs_n[2];
        con = eff.comp[0];
        bad = eff.comp[2] || eff.comp[3] || (con && eff.mode == ENC_RSVD)
           || (con && eff.mode == ENC_SINGLE && eff.src != 3'd2)
           || (con && eff.mode == ENC_DUAL && !eff.mst)
           || (eff.comp[1] && !(con && eff.mode == ENC_DUAL));
        foreach (src[k]) src[k] = -1;
        if (!bad) begin
            src[0] = con ? 6 : 2;
            if (con) begin
                src[4] = 2;
                if (eff.mode != ENC_SINGLE) src[5] = 3;
            end
            if (eff.mst) begin
                src[1] = eff.comp[1] ? 7 : ((con && eff.mode == ENC_SPLIT) ? -1 : 3);
                src[2] = eff.alt[0] ? 4 : 2;
                src[3] = eff.alt[1] ? 5 : 3;
            end
        end
        for (int k = 0; k < N_LANE; k++) begin
            e.lane[k] = (src[k] < 0) ? STRM_IDLE : strm(src[k]);
            e.sec[k]  = e.lane[k].meta[SEC_BIT];
        end
        e.err = bad;
        e.mm  = !bad && con && eff.mode == ENC_SPLIT &&
                ((in_de[2] != in_de[3]) || (in_vs_n[2] != in_vs_n[3]) || (in_hs_n[2] != in_hs_n[3]));
        return e;
    endfunction

    task automatic compare(input snap_t act, input snap_t exp, input string t);
        checks++;
        if (act !== exp) begin
            errors++;
            for (int k = 0; k < N_LANE; k++) begin
                if (act.lane[k] !== exp.lane[k] || act.sec[k] !== exp.sec[k]) begin
                    $display("FAIL %s lane %0d act de=%b vs=%b hs=%b sec=%b pix=%h exp de=%b vs=%b hs=%b sec=%b pix=%h",
                             t, k, act.lane[k].de, act.lane[k].vs_n, act.lane[k].hs_n, act.sec[k], act.lane[k].pix,
                             exp.lane[k].de, exp.lane[k].vs_n, exp.lane[k].hs_n, exp.sec[k], exp.lane[k].pix);
                    return;
                end
            end
            $display("FAIL %s flags act err=%b mm=%b exp err=%b mm=%b", t, act.err, act.mm, exp.err, exp.mm);
        end
    endtask

    // Driver: one input cycle, expectation queued
    task automatic step(input logic vs2, input bit lock23);
        @(negedge clk);
        for (int i = 0; i < N_IN; i++) begin
            in_pix[i]  = PIX_W'({$urandom(), $urandom()});
            in_meta[i] = META_W'({$urandom(), $urandom()});
            in_de[i]   = 1'($urandom());
            in_hs_n[i] = 1'($urandom());
            in_vs_n[i] = (i == 2) ? vs2 : 1'($urandom());
        end
        for (int r = 0; r < N_RET; r++) begin
            ret_pix[r]  = PIX_W'({$urandom(), $urandom()});
            ret_meta[r] = META_W'({$urandom(), $urandom()});
            ret_de[r]   = 1'($urandom());
            ret_vs_n[r] = 1'($urandom());
            ret_hs_n[r] = 1'($urandom());
        end
        if (lock23) begin
            in_de[3]   = in_de[2];
            in_vs_n[3] = in_vs_n[2];
            in_hs_n[3] = in_hs_n[2];
        end
        exp_q.push_back(predict());
        tag_q.push_back(tag);
    endtask

    // Monitor: pops one expectation per registered result
    always @(posedge clk) begin
        #2;
        if (exp_q.size() != 0) compare(observe(), exp_q.pop_front(), tag_q.pop_front());
    end

    // New settings present but ignored, then a frame start, then the new frame
    task automatic frame(input logic mst, input logic [3:0] comp, input logic [1:0] mode,
                         input logic [2:0] src, input logic [1:0] alt, input bit lock, input string t);
        cfg_mst = mst; cfg_comp_out = comp; cfg_enc_mode = mode; cfg_enc_src = src; cfg_alt_sel = alt;
        tag = {"R11 hold before ", t};
        repeat (3) step(1'b1, lock);
        tag = {"R11 frame start ", t};
        step(1'b0, lock);
        tag = t;
        repeat (8) step(1'b1, lock);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        begin
            snap_t idle;
            idle.lane = {N_LANE{STRM_IDLE}};
            idle.sec  = '0;
            idle.err  = 1'b0;
            idle.mm   = 1'b0;
            compare(observe(), idle, "R1 reset state");
        end
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R2 R3 R9 sst direct";
        repeat (10) step(1'b1, 1'b0);
        frame(1'b1, 4'b0000, 2'd0, 3'd0, 2'b00, 1'b0, "R4 mst base");
        frame(1'b1, 4'b0000, 2'd0, 3'd0, 2'b11, 1'b0, "R4 alt inputs");
        frame(1'b1, 4'b0000, 2'd0, 3'd0, 2'b01, 1'b0, "R4 mixed alt");
        frame(1'b0, 4'b0001, 2'd0, 3'd2, 2'b00, 1'b0, "R5 single encoder");
        frame(1'b0, 4'b0001, 2'd1, 3'd0, 2'b00, 1'b1, "R6 R10 split sst aligned");
        tag = "R10 split mismatch";
        repeat (12) step(1'b1, 1'b0);
        frame(1'b1, 4'b0001, 2'd1, 3'd0, 2'b10, 1'b1, "R6 split mst");
        frame(1'b1, 4'b0011, 2'd2, 3'd0, 2'b01, 1'b0, "R7 R10 dual compressed");
        frame(1'b1, 4'b0001, 2'd2, 3'd0, 2'b00, 1'b0, "R7 dual raw port1");
        frame(1'b1, 4'b0100, 2'd0, 3'd2, 2'b00, 1'b0, "R8 comp port2");
        frame(1'b1, 4'b0001, 2'd0, 3'd4, 2'b00, 1'b0, "R8 bad encoder source");
        frame(1'b0, 4'b0001, 2'd2, 3'd0, 2'b00, 1'b0, "R8 dual in sst");
        frame(1'b1, 4'b0001, 2'd3, 3'd0, 2'b00, 1'b0, "R8 reserved mode");
        frame(1'b1, 4'b0010, 2'd0, 3'd2, 2'b00, 1'b0, "R8 port1 without dual");
        frame(1'b1, 4'b1000, 2'd1, 3'd2, 2'b11, 1'b1, "R8 comp port3");
        frame(1'b1, 4'b0000, 2'd0, 3'd0, 2'b10, 1'b0, "R8 R4 recover");
        repeat (3) @(posedge clk);
        #3;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired after 20000 cycles");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule